// File: doc/BRIEF.md
# Split-Word 30-Bit Address Sequencer

This block turns a 16-bit address-generation datapath into one that builds 30-bit addresses from two 15-bit halves, one half per cycle, so a full address appears every two cycles. An address lives in a pair of registers: the even index holds the low word and the odd index holds the high word. Each half-operation returns its result to the register it read and drives that result on the address port. Bit 15 of the port tags the half being driven. The first half of a pair saves its carry, borrow or shifted-out bit, and the second half consumes it.

For increments, decrements, offset adds and subtracts and left shifts, the low word goes first. For arithmetic right shifts the order is reversed: the high word goes first, and its bit 0 drops into the top of the low word. Offset and limit registers carry no half restriction. After the high-word step of an arithmetic operation, a compare flag reports whether the joined 30-bit address has reached or passed a 30-bit limit. That limit is assembled from the limit register named by each of the two steps. The reload-on-compare and alternate-instruction features of the wider device are not part of this block.

Top module: `dpseq_top`

## Requirements
- R1: `op_code` encodings are 0 idle, 1 load address register, 2 load offset register, 3 load limit register, 4 increment, 5 decrement, 6 add offset, 7 subtract offset, 8 shift left, 9 arithmetic shift right, 10 read address register, and any other code is idle. A load writes `d_in[14:0]` into the register picked by `r_idx`, `b_idx` or `c_idx`, and `d_in[15]` is ignored. A read drives `{r_idx[0], value}` with no change to state.
- R2: For codes 4 to 8, an even `r_idx` is the first half. It stores the 15-bit result in that register and saves bit 15 of the zero-extended 16-bit result (the carry or borrow), or the shifted-out bit 14 for a left shift.
- R3: For codes 4 to 8, an odd `r_idx` is the second half. It adds the saved bit (increment, add), subtracts it (decrement, subtract) or shifts it in at bit 0 (left shift). The joined pair then equals the 30-bit result of the operation.
- R4: For code 9, the odd (high) index is the first half. It keeps bit 14 and saves its bit 0. The following even-index step places the saved bit at bit 14, so the pair equals a 30-bit arithmetic right shift.
- R5: In the cycle after an addressing or read operation, `y_en` is 1 and `y_out` is `{r_idx[0], result}`, where the result is the updated half. After every other operation, `y_en` is 0 and `y_out` is 0.
- R6: The saved link bit changes only on a first-half operation. Idle, load and read operations between the two halves leave it unchanged.
- R7: In the cycle after a high-word (odd index) step of code 4 or 6, `cmp_out` is 1 when {new high word, partner low register} is greater than or equal to {limit[`c_idx`], limit[index given on the first-half step]}. For codes 5 and 7 the test is less than or equal. In every other case `cmp_out` is 0.
- R8: Synchronous active-high `rst` clears every register, the saved link bit, the saved limit index and all outputs.
- R9: Each pair wraps modulo 2^30: adding one to 0x3FFFFFFF gives 0, and subtracting one from 0 gives 0x3FFFFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_code | input | 4 | Operation code (see R1) |
| r_idx | input | 4 | Address register index; bit 0 selects the half |
| b_idx | input | 2 | Offset register index |
| c_idx | input | 2 | Limit register index |
| d_in | input | 16 | Load data; bit 15 ignored |
| y_out | output | 16 | Tagged half address: bit 15 half tag, bits 14:0 value |
| y_en | output | 1 | Address port is driving |
| cmp_out | output | 1 | 30-bit limit reached, valid after a high-word arithmetic step |

## Verification
A wrong saved link bit stays hidden on the first half. It shows up one cycle after the second half, as a high word off by exactly one, or with the wrong bit 0 after a shift. A broken half-order decision or a wrong tag shows at once on `y_out[15]`, or as a right shift that reverses the bit drop. A wrong saved limit index shows only on `cmp_out` after a high step, so compare checks are placed exactly at the equality boundary and one step either side of it. Bit-15 leakage from the data port shows on the next read.

// File: rtl/dpseq_pkg.sv
package dpseq_pkg;

    localparam int HALF_W = 15;
    localparam int FULL_W = 2 * HALF_W;

    typedef logic [HALF_W-1:0] half_t;

    typedef enum logic [3:0] {
        OP_IDLE  = 4'd0,
        OP_LDR   = 4'd1,
        OP_LDB   = 4'd2,
        OP_LDC   = 4'd3,
        OP_INC   = 4'd4,
        OP_DEC   = 4'd5,
        OP_ADD   = 4'd6,
        OP_SUB   = 4'd7,
        OP_SHL   = 4'd8,
        OP_SHR   = 4'd9,
        OP_READ  = 4'd10
    } op_e;

    typedef struct packed {
        half_t value;
        logic  link;
    } half_res_t;

    function automatic logic is_addr_op(op_e op);
        return (op == OP_INC) || (op == OP_DEC) || (op == OP_ADD) ||
               (op == OP_SUB) || (op == OP_SHL) || (op == OP_SHR);
    endfunction

    function automatic logic is_arith_op(op_e op);
        return (op == OP_INC) || (op == OP_DEC) || (op == OP_ADD) || (op == OP_SUB);
    endfunction

    function automatic logic counts_up(op_e op);
        return (op == OP_INC) || (op == OP_ADD);
    endfunction

    // Right shifts begin on the high word; every other op begins on the low word.
    function automatic logic is_first_half(op_e op, logic odd_idx);
        return (op == OP_SHR) ? odd_idx : !odd_idx;
    endfunction

endpackage

// File: rtl/dpseq_regfile.sv
module dpseq_regfile #(
    parameter int DEPTH = 16,
    parameter int WIDTH = 15,
    parameter int NRD   = 2,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     wr_en,
    input  logic [AW-1:0]            wr_addr,
    input  logic [WIDTH-1:0]         wr_data,
    input  logic [NRD-1:0][AW-1:0]   rd_addr,
    output logic [NRD-1:0][WIDTH-1:0] rd_data
);

    logic [WIDTH-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= '0;
            end
        end else if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
    end

    for (genvar g = 0; g < NRD; g++) begin : g_rd
        assign rd_data[g] = mem[rd_addr[g]];
    end

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> mem[$past(wr_addr)] == $past(wr_data)); // R1

endmodule

// File: rtl/dpseq_half_alu.sv
module dpseq_half_alu
    import dpseq_pkg::*;
(
    input  op_e       op,
    input  half_t     a,
    input  half_t     b,
    input  logic      link_in,
    input  logic      is_first,
    output half_res_t res
);

    logic [HALF_W:0] ext_a;
    logic [HALF_W:0] ext_b;
    logic [HALF_W:0] wide;
    logic [HALF_W:0] step;
    logic            cin;

    assign ext_a = {1'b0, a};
    assign ext_b = {1'b0, b};
    assign cin   = is_first ? 1'b0 : link_in;

    always_comb begin
        res.value = a;
        res.link  = link_in;
        wide      = '0;
        step      = {{HALF_W{1'b0}}, (is_first ? 1'b1 : link_in)};
        case (op)
            OP_INC: begin
                wide      = ext_a + step;
                res.value = wide[HALF_W-1:0];
                res.link  = wide[HALF_W];
            end
            OP_DEC: begin
                wide      = ext_a - step;
                res.value = wide[HALF_W-1:0];
                res.link  = wide[HALF_W];
            end
            OP_ADD: begin
                wide      = ext_a + ext_b + {{HALF_W{1'b0}}, cin};
                res.value = wide[HALF_W-1:0];
                res.link  = wide[HALF_W];
            end
            OP_SUB: begin
                wide      = ext_a - ext_b - {{HALF_W{1'b0}}, cin};
                res.value = wide[HALF_W-1:0];
                res.link  = wide[HALF_W];
            end
            OP_SHL: begin
                res.value = {a[HALF_W-2:0], cin};
                res.link  = a[HALF_W-1];
            end
            OP_SHR: begin
                res.value = {(is_first ? a[HALF_W-1] : link_in), a[HALF_W-1:1]};
                res.link  = a[0];
            end
            default: begin
                res.value = a;
                res.link  = link_in;
            end
        endcase
    end

endmodule

// File: rtl/dpseq_cmp.sv
module dpseq_cmp #(
    parameter int W = 30
) (
    input  logic [W-1:0] addr,
    input  logic [W-1:0] limit,
    input  logic         up,
    output logic         hit
);

    always_comb begin
        if (up) begin
            hit = (addr >= limit);
        end else begin
            hit = (addr <= limit);
        end
    end

endmodule

// File: rtl/dpseq_top.sv
module dpseq_top
    import dpseq_pkg::*;
#(
    parameter int R_COUNT = 16,
    parameter int B_COUNT = 4,
    parameter int C_COUNT = 4,
    localparam int RA_W   = $clog2(R_COUNT),
    localparam int BA_W   = $clog2(B_COUNT),
    localparam int CA_W   = $clog2(C_COUNT),
    localparam int PORT_W = HALF_W + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [3:0]        op_code,
    input  logic [RA_W-1:0]   r_idx,
    input  logic [BA_W-1:0]   b_idx,
    input  logic [CA_W-1:0]   c_idx,
    input  logic [PORT_W-1:0] d_in,
    output logic [PORT_W-1:0] y_out,
    output logic              y_en,
    output logic              cmp_out
);

    op_e       op;
    logic      odd_idx;
    logic      addr_op;
    logic      arith_op;
    logic      first_half;
    half_t     load_val;
    logic      unused_data_msb;

    logic      link_q;
    logic [CA_W-1:0] saved_c_q;

    logic [PORT_W-1:0] y_q;
    logic              y_en_q;
    logic              cmp_q;

    logic [1:0][RA_W-1:0]   r_rd_addr;
    logic [1:0][HALF_W-1:0] r_rd_data;
    logic [0:0][BA_W-1:0]   b_rd_addr;
    logic [0:0][HALF_W-1:0] b_rd_data;
    logic [1:0][CA_W-1:0]   c_rd_addr;
    logic [1:0][HALF_W-1:0] c_rd_data;

    half_t     r_val;
    half_t     r_partner;
    half_res_t alu_res;
    logic      r_wr_en;
    half_t     r_wr_data;
    logic      cmp_hit;

    assign op              = op_e'(op_code);
    assign odd_idx         = r_idx[0];
    assign addr_op         = is_addr_op(op);
    assign arith_op        = is_arith_op(op);
    assign first_half      = is_first_half(op, odd_idx);
    assign load_val        = d_in[HALF_W-1:0];
    assign unused_data_msb = d_in[PORT_W-1];

    // Address register file: port 0 the operand, port 1 the pair partner.
    assign r_rd_addr[0] = r_idx;
    assign r_rd_addr[1] = r_idx ^ RA_W'(1);
    assign r_val        = r_rd_data[0];
    assign r_partner    = r_rd_data[1];
    assign r_wr_en      = (op == OP_LDR) || addr_op;
    assign r_wr_data    = (op == OP_LDR) ? load_val : alu_res.value;

    dpseq_regfile #(.DEPTH(R_COUNT), .WIDTH(HALF_W), .NRD(2)) u_rfile (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (r_wr_en),
        .wr_addr (r_idx),
        .wr_data (r_wr_data),
        .rd_addr (r_rd_addr),
        .rd_data (r_rd_data)
    );

    assign b_rd_addr[0] = b_idx;

    dpseq_regfile #(.DEPTH(B_COUNT), .WIDTH(HALF_W), .NRD(1)) u_bfile (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (op == OP_LDB),
        .wr_addr (b_idx),
        .wr_data (load_val),
        .rd_addr (b_rd_addr),
        .rd_data (b_rd_data)
    );

    // Limit file: port 0 this step's limit, port 1 the one named on the first half.
    assign c_rd_addr[0] = c_idx;
    assign c_rd_addr[1] = saved_c_q;

    dpseq_regfile #(.DEPTH(C_COUNT), .WIDTH(HALF_W), .NRD(2)) u_cfile (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (op == OP_LDC),
        .wr_addr (c_idx),
        .wr_data (load_val),
        .rd_addr (c_rd_addr),
        .rd_data (c_rd_data)
    );

    dpseq_half_alu u_alu (
        .op       (op),
        .a        (r_val),
        .b        (b_rd_data[0]),
        .link_in  (link_q),
        .is_first (first_half),
        .res      (alu_res)
    );

    dpseq_cmp #(.W(FULL_W)) u_cmp (
        .addr  ({alu_res.value, r_partner}),
        .limit ({c_rd_data[0], c_rd_data[1]}),
        .up    (counts_up(op)),
        .hit   (cmp_hit)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            link_q    <= 1'b0;
            saved_c_q <= '0;
        end else if (addr_op && first_half) begin
            link_q    <= alu_res.link;
            saved_c_q <= c_idx;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            y_q    <= '0;
            y_en_q <= 1'b0;
            cmp_q  <= 1'b0;
        end else begin
            cmp_q <= arith_op && odd_idx && cmp_hit;
            if (addr_op) begin
                y_q    <= {odd_idx, alu_res.value};
                y_en_q <= 1'b1;
            end else if (op == OP_READ) begin
                y_q    <= {odd_idx, r_val};
                y_en_q <= 1'b1;
            end else begin
                y_q    <= '0;
                y_en_q <= 1'b0;
            end
        end
    end

    assign y_out   = y_q;
    assign y_en    = y_en_q;
    assign cmp_out = cmp_q;

    AST_TAG_FOLLOWS_INDEX: assert property (@(posedge clk) disable iff (rst)
        y_en |-> y_out[PORT_W-1] == $past(r_idx[0])); // R5

    AST_CMP_ONLY_AFTER_HIGH: assert property (@(posedge clk) disable iff (rst)
        cmp_out |-> ($past(arith_op) && $past(r_idx[0]))); // R7

    AST_LINK_HELD: assert property (@(posedge clk) disable iff (rst)
        !addr_op |=> $stable(link_q)); // R6

    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (y_out == '0 && !y_en && !cmp_out)); // R8

endmodule

// File: tb/tb_dpseq_top.sv
`timescale 1ns/1ps
module tb_dpseq_top;

    localparam logic [3:0] C_IDLE = 4'd0, C_LDR = 4'd1, C_LDB = 4'd2, C_LDC = 4'd3;
    localparam logic [3:0] C_INC = 4'd4, C_DEC = 4'd5, C_ADD = 4'd6, C_SUB = 4'd7;
    localparam logic [3:0] C_SHL = 4'd8, C_SHR = 4'd9, C_READ = 4'd10;

    localparam int NV = 9;
    localparam logic [3:0]  V_OP [NV] = '{C_ADD, C_SUB, C_INC, C_DEC, C_SHL, C_SHR, C_SHR, C_INC, C_SUB};
    localparam logic [29:0] V_A  [NV] = '{30'h00007FFF, 30'h00008000, 30'h00007FFF, 30'h00008000,
                                          30'h00004000, 30'h00008000, 30'h20000001, 30'h3FFFFFFF,
                                          30'h00000000};
    localparam logic [29:0] V_B  [NV] = '{30'h00000001, 30'h00000001, 30'h0, 30'h0, 30'h0, 30'h0,
                                          30'h0, 30'h0, 30'h00000001};

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  op_code = '0;
    logic [3:0]  r_idx = '0;
    logic [1:0]  b_idx = '0;
    logic [1:0]  c_idx = '0;
    logic [15:0] d_in = '0;
    logic [15:0] y_out;
    logic        y_en;
    logic        cmp_out;

    int checks = 0;
    int errors = 0;
    logic [31:0] seed = 32'h1234_5678;

    always #2.5 clk = ~clk;

    dpseq_top dut (
        .clk(clk), .rst(rst), .op_code(op_code), .r_idx(r_idx), .b_idx(b_idx),
        .c_idx(c_idx), .d_in(d_in), .y_out(y_out), .y_en(y_en), .cmp_out(cmp_out)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic issue(input logic [3:0] op, input int r, input int b, input int c,
                         input logic [15:0] d);
        op_code = op;
        r_idx   = 4'(r);
        b_idx   = 2'(b);
        c_idx   = 2'(c);
        d_in    = d;
        @(posedge clk);
        #1;
        op_code = C_IDLE;
    endtask

    task automatic rnd(output logic [31:0] v);
        seed = seed ^ (seed << 13);
        seed = seed ^ (seed >> 17);
        seed = seed ^ (seed << 5);
        v = seed;
    endtask

    function automatic logic [29:0] ref30(input logic [3:0] op, input logic [29:0] a,
                                          input logic [29:0] b);
        case (op)
            C_INC:   return a + 30'd1;
            C_DEC:   return a - 30'd1;
            C_ADD:   return a + b;
            C_SUB:   return a - b;
            C_SHL:   return {a[28:0], 1'b0};
            C_SHR:   return {a[29], a[29:1]};
            default: return a;
        endcase
    endfunction

    // Loads a pair into R0/R1, B0/B1, C0/C1, runs both halves and checks each step.
    task automatic run_pair(input string tag, input logic [3:0] op, input logic [29:0] a,
                            input logic [29:0] b, input logic [29:0] c, input logic msb);
        logic [29:0] res;
        logic        exp_cmp;
        res = ref30(op, a, b);
        issue(C_LDR, 0, 0, 0, {msb, a[14:0]});
        issue(C_LDR, 1, 0, 0, {msb, a[29:15]});
        issue(C_LDB, 0, 0, 0, {msb, b[14:0]});
        issue(C_LDB, 0, 1, 0, {msb, b[29:15]});
        issue(C_LDC, 0, 0, 0, {msb, c[14:0]});
        issue(C_LDC, 0, 0, 1, {msb, c[29:15]});
        if (op == C_SHR) begin
            issue(op, 1, 1, 1, 16'h0);
            chk({tag, " R4 high first"}, {15'h0, y_en, y_out}, {15'h0, 1'b1, 1'b1, res[29:15]});
            chk({tag, " R7 no cmp on shift"}, {31'h0, cmp_out}, 32'h0);
            issue(op, 0, 0, 0, 16'h0);
            chk({tag, " R4 low second"}, {15'h0, y_en, y_out}, {15'h0, 1'b1, 1'b0, res[14:0]});
            chk({tag, " R7 no cmp on low"}, {31'h0, cmp_out}, 32'h0);
        end else begin
            issue(op, 0, 0, 0, 16'h0);
            chk({tag, " R2 low first"}, {15'h0, y_en, y_out}, {15'h0, 1'b1, 1'b0, res[14:0]});
            chk({tag, " R7 no cmp on low"}, {31'h0, cmp_out}, 32'h0);
            issue(op, 1, 1, 1, 16'h0);
            chk({tag, " R3 high second"}, {15'h0, y_en, y_out}, {15'h0, 1'b1, 1'b1, res[29:15]});
            case (op)
                C_INC, C_ADD: exp_cmp = (res >= c);
                C_DEC, C_SUB: exp_cmp = (res <= c);
                default:      exp_cmp = 1'b0;
            endcase
            chk({tag, " R7 cmp"}, {31'h0, cmp_out}, {31'h0, exp_cmp});
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual running expected done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] v1, v2, v3;
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;
        // R8: outputs cleared by reset
        chk("R8 reset outputs", {14'h0, cmp_out, y_en, y_out}, 32'h0);
        // R8: link starts at 0, so a high increment adds nothing; limit 0 met
        issue(C_INC, 1, 0, 0, 16'h0);
        chk("R8 cleared link", {15'h0, y_en, y_out}, {15'h0, 1'b1, 16'h8000});
        chk("R8 R7 zero limit reached", {31'h0, cmp_out}, 32'h1);
        issue(C_READ, 5, 0, 0, 16'h0);
        chk("R8 cleared register read", {15'h0, y_en, y_out}, {15'h0, 1'b1, 16'h8000});
        // R5: idle drives nothing
        issue(C_IDLE, 0, 0, 0, 16'hFFFF);
        chk("R5 idle port", {15'h0, y_en, y_out}, 32'h0);
        // R1: data bit 15 ignored on loads
        issue(C_LDR, 2, 0, 0, 16'hFFFF);
        chk("R5 load does not drive", {15'h0, y_en, y_out}, 32'h0);
        issue(C_READ, 2, 0, 0, 16'h0);
        chk("R1 msb dropped even", {15'h0, y_en, y_out}, {15'h0, 1'b1, 16'h7FFF});
        issue(C_LDR, 3, 0, 0, 16'h8001);
        issue(C_READ, 3, 0, 0, 16'h0);
        chk("R1 odd tag", {15'h0, y_en, y_out}, {15'h0, 1'b1, 16'h8001});

        // Table walk
        for (int i = 0; i < NV; i++) begin
            run_pair((i >= 7) ? "R9 vec" : "vec", V_OP[i], V_A[i], V_B[i], 30'h0, i[0]);
        end

        // R7 boundaries
        run_pair("R7 add eq", C_ADD, 30'h01234567, 30'h00100001, 30'h01334568, 1'b0);
        run_pair("R7 add above", C_ADD, 30'h01234567, 30'h00100001, 30'h01334569, 1'b0);
        run_pair("R7 sub eq", C_SUB, 30'h01234567, 30'h00008001, 30'h0122C566, 1'b1);
        run_pair("R7 sub below", C_SUB, 30'h01234567, 30'h00008001, 30'h0122C565, 1'b1);
        run_pair("R7 dec eq", C_DEC, 30'h00018000, 30'h0, 30'h00017FFF, 1'b0);

        // R6: non-addressing ops between halves keep the saved carry
        issue(C_LDR, 4, 0, 0, 16'h7FFF);
        issue(C_LDR, 5, 0, 0, 16'h0002);
        issue(C_LDB, 0, 2, 0, 16'h0001);
        issue(C_LDB, 0, 3, 0, 16'h0010);
        issue(C_ADD, 4, 2, 0, 16'h0);
        chk("R6 R2 low carry out", {15'h0, y_en, y_out}, {15'h0, 1'b1, 16'h0000});
        issue(C_IDLE, 0, 0, 0, 16'h0);
        issue(C_LDB, 0, 0, 0, 16'h1234);
        issue(C_LDR, 6, 0, 0, 16'h7FFF);
        issue(C_LDC, 0, 0, 2, 16'h0055);
        issue(C_READ, 6, 0, 0, 16'h0);
        issue(C_ADD, 5, 3, 0, 16'h0);
        chk("R6 carry kept across idle ops", {15'h0, y_en, y_out}, {15'h0, 1'b1, 16'h8013});

        // Random pairs against 30-bit reference
        for (int k = 0; k < 40; k++) begin
            logic [3:0] op;
            rnd(v1); rnd(v2); rnd(v3);
            op = 4'(4 + (v3 % 6));
            run_pair("rand", op, v1[29:0], v2[29:0],
                     v3[3] ? ref30(op, v1[29:0], v2[29:0]) : v3[31:2], v3[4]);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule